// File: doc/BRIEF.md
# Real-Time Clock Update and Interrupt Core

This block is the timing and interrupt core of a real-time clock. It counts ticks of a 32.768 kHz time base. The ticks arrive as a one-cycle enable `tick_32k` in the fast system clock domain. Once per second the block runs an update cycle, which lasts a fixed number of ticks. An update-in-progress status bit goes high a fixed number of ticks before each update starts and stays high until the update ends. Calendar arithmetic, alarm comparison, battery supervision and RAM are outside the block. A neighbouring comparator reports an alarm hit on `alarm_match`.

The block has three interrupt sources:
- the update-ended event;
- the alarm event, which falls one tick after the update ends;
- a periodic event, whose rate is taken from the divider taps.

Each source has a flag in a status byte. All three share one active-high request line. A request is raised only when the source's enable bit is already set at the moment the event occurs. Reading the status byte returns the flags and the request level, and clears them in the same step. An event that arrives in the read cycle is not lost. An event that repeats while its flag is still set is absorbed.

A small register port gives access to three registers:
- a mode register: divider mode, rate select and the update-in-progress bit;
- an enable register;
- the status register.

Read data appears one cycle after the read strobe.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the mode register reads 0x20 (divider running, rate 0, update-in-progress 0), the enable and status registers read 0, `irq` is low and the divider phase is 0.
- R2: Divider mode is bits 6:4 of the mode register. The value 010 runs the divider. Any other value freezes the divider, so no event occurs and update-in-progress holds. Values 11x also force the divider phase, the update state and update-in-progress to zero.
- R3: Update-in-progress is bit 7 of the mode register. After a tick, it is 1 when either of these holds:
  - the divider phase is in the last UIP_LEAD ticks of the second (default 8 ticks, about 244 µs);
  - an update is still running.

  It is 0 otherwise.
- R4: An update starts at the tick that wraps the phase from its last value to 0. It ends UPD_TICKS ticks later. At that ending tick the update-ended flag, status bit 4, is set.
- R5: The alarm flag, status bit 5, is set on the first tick after an update ends, provided `alarm_match` is high on that tick.
- R6: The periodic flag is status bit 6. Rate select is bits 3:0 of the mode register, and a value of 0 disables the periodic event. A value r > 0 sets the flag on every tick whose phase has its low k bits all ones, where k = min(r+1, TB_LOG2-1). This gives periods of 2^k ticks, from 4 ticks (122 µs) up to half a second.
- R7: A flag is set by its event whatever the enable. The enables are bits 6:4 of the enable register, in the same bit order as the flags. `irq` rises only for an event whose flag was clear and whose enable was set when the event occurred. Setting an enable afterwards does not raise `irq`.
- R8: A status read returns {request, periodic, alarm, update-ended, 0000} one cycle after `rd_en`. It clears every flag and drops `irq`.
- R9: An event arriving in the same cycle as a status read reads as 0 in that read. Its flag stays set, and its request is raised, for the next read.
- R10: An event that repeats while its flag is still set has no further effect. A single status read then clears it.
- R11: Status bit 7 returns the level of `irq` in the cycle of the read.
- R12: The register addresses are:
  - 0: mode; bits 6:0 are writable and bit 7 is read-only;
  - 1: enable; bits 6:4 are writable and the other bits read 0;
  - 2: status; read-only, and writes are ignored;
  - 3: reads 0.

  Reads of addresses 0, 1 and 3 change nothing. `rd_data` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle pulse per time-base tick |
| alarm_match | input | 1 | Alarm comparator hit, sampled on ticks |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Shared active-high interrupt request |

## Verification
A status read and an event can fall in the same cycle. In that case the clear and the set compete for the same flag.

The bench provokes this collision. During a sweep over every rate-select value, it raises `tick_32k` and a status read on the same clock edge. Across the sweep this happens for periodic, update-ended and alarm events.

The bench judges the result against an arithmetic model of the divider phase. The model shows whether the read returned the flags from before that tick. It also shows whether the new event survived into the next read, and whether the new event raised the request when its enable was set.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  typedef enum logic [1:0] {
    RA_MODE   = 2'd0,
    RA_ENABLE = 2'd1,
    RA_STATUS = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  localparam int NUM_SRC = 3;
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;
  localparam int FLAG_LSB = 4;

  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef struct packed {
    logic [2:0] div_mode;
    logic [3:0] rate_sel;
  } mode_t;

  function automatic logic div_running(input logic [2:0] m);
    return m == DIV_RUN;
  endfunction

  function automatic logic div_clearing(input logic [2:0] m);
    return m[2:1] == 2'b11;
  endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TB_LOG2   = 15,
  parameter int UIP_LEAD  = 8,
  parameter int UPD_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [2:0]         div_mode,
  input  logic               alarm_match,
  output logic [TB_LOG2-1:0] phase,
  output logic               step,
  output logic               uip,
  output logic               ev_upd_end,
  output logic               ev_alarm
);
  import rtc_irq_pkg::*;

  localparam int TPS      = 1 << TB_LOG2;
  localparam int UIP_FROM = TPS - UIP_LEAD;
  localparam int UPD_W    = $clog2(UPD_TICKS + 1);

  logic [TB_LOG2-1:0] cnt_q, cnt_n;
  logic [UPD_W-1:0]   left_q, left_n;
  logic               arm_q, uip_q;
  logic               run, clr, wrap, last_upd;

  always_comb begin
    run      = div_running(div_mode);
    clr      = div_clearing(div_mode);
    step     = tick && run;
    wrap     = &cnt_q;
    last_upd = (left_q == UPD_W'(1));
    cnt_n    = cnt_q + 1'b1;
    if (wrap)
      left_n = UPD_W'(UPD_TICKS);
    else if (left_q != '0)
      left_n = left_q - 1'b1;
    else
      left_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      left_q <= '0;
      arm_q  <= 1'b0;
      uip_q  <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_n;
      left_q <= left_n;
      arm_q  <= last_upd;
      uip_q  <= (int'(cnt_n) >= UIP_FROM) || (left_n != '0);
    end
  end

  assign phase      = cnt_q;
  assign uip        = uip_q;
  assign ev_upd_end = step && last_upd;
  assign ev_alarm   = step && arm_q && alarm_match;

  AST_UIP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (step && wrap) |-> uip); // R3

  AST_FROZEN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(phase)); // R2

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int TB_LOG2 = 15
) (
  input  logic [TB_LOG2-1:0] phase,
  input  logic               step,
  input  logic [3:0]         rate_sel,
  output logic               ev_per
);
  localparam int MAXK = TB_LOG2 - 1;

  logic [TB_LOG2-1:0] hit;

  for (genvar j = 0; j < TB_LOG2; j++) begin : g_tap
    assign hit[j] = &phase[j:0];
  end

  int k;

  always_comb begin
    k = int'(rate_sel) + 1;
    if (k > MAXK) k = MAXK;
    ev_per = step && (rate_sel != 4'd0) && hit[k-1];
  end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  input  logic         rd_clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q, pend_q, kept, fresh, flags_d, pend_d;
  logic         irq_q;

  always_comb begin
    kept    = rd_clr ? '0 : flags_q;
    fresh   = ev & ~kept;
    flags_d = kept | ev;
    pend_d  = (rd_clr ? '0 : pend_q) | (fresh & en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pend_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
      irq_q   <= |pend_d;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ev == '0) |=> !irq); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && ev == '0) |=> $stable(flags)); // R10

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev))); // R9

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flags != '0)); // R7

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int TB_LOG2   = 15,
  parameter int UIP_LEAD  = 8,
  parameter int UPD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k,
  input  logic       alarm_match,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  import rtc_irq_pkg::*;

  mode_t              mode_q;
  logic [NUM_SRC-1:0] en_q, ev, flags;
  logic [TB_LOG2-1:0] phase;
  logic               step, uip, ev_upd_end, ev_alarm, ev_per, rd_clr, irq_w;
  logic [7:0]         rd_data_q;
  reg_addr_e          ra;
  logic               unused_wr;

  assign ra        = reg_addr_e'(addr);
  assign rd_clr    = rd_en && (ra == RA_STATUS);
  assign unused_wr = wr_data[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '{div_mode: DIV_RUN, rate_sel: 4'd0};
      en_q   <= '0;
    end else if (wr_en) begin
      case (ra)
        RA_MODE:   mode_q <= mode_t'(wr_data[6:0]);
        RA_ENABLE: en_q   <= wr_data[FLAG_LSB +: NUM_SRC];
        default:   ;
      endcase
    end
  end

  rtc_timebase #(
    .TB_LOG2  (TB_LOG2),
    .UIP_LEAD (UIP_LEAD),
    .UPD_TICKS(UPD_TICKS)
  ) u_tb (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_32k),
    .div_mode   (mode_q.div_mode),
    .alarm_match(alarm_match),
    .phase      (phase),
    .step       (step),
    .uip        (uip),
    .ev_upd_end (ev_upd_end),
    .ev_alarm   (ev_alarm)
  );

  rtc_periodic #(.TB_LOG2(TB_LOG2)) u_per (
    .phase   (phase),
    .step    (step),
    .rate_sel(mode_q.rate_sel),
    .ev_per  (ev_per)
  );

  always_comb begin
    ev          = '0;
    ev[SRC_UPD] = ev_upd_end;
    ev[SRC_ALM] = ev_alarm;
    ev[SRC_PER] = ev_per;
  end

  rtc_irq_flags #(.N(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .ev    (ev),
    .en    (en_q),
    .rd_clr(rd_clr),
    .flags (flags),
    .irq   (irq_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      case (ra)
        RA_MODE:   rd_data_q <= {uip, mode_q};
        RA_ENABLE: rd_data_q <= {1'b0, en_q, 4'b0000};
        RA_STATUS: rd_data_q <= {irq_w, flags, 4'b0000};
        default:   rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_data_q;
  assign irq     = irq_w;

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !div_running(mode_q.div_mode) |-> (ev == '0)); // R2

  AST_IRQF_TRACKS: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> (rd_data[7] == $past(irq_w))); // R11

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R12

endmodule

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;

  localparam int TB_LOG2 = 5;
  localparam int LEAD    = 3;
  localparam int UPD     = 2;
  localparam int TPS     = 1 << TB_LOG2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b0;
  logic       alarm_match = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl #(.TB_LOG2(TB_LOG2), .UIP_LEAD(LEAD), .UPD_TICKS(UPD)) uut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .alarm_match(alarm_match),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  int nchk = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int       mcnt = 0, mul = 0;
  bit       marm = 0, muip = 0;
  bit [2:0] mflags = 0, mpend = 0, men = 0;
  bit [2:0] mdv = 3'b010;
  bit [3:0] mrs = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    bit [2:0] ev;
    int k, mask, cn, nul;
    if (mdv != 3'b010) return;
    k = mrs + 1;
    if (k > TB_LOG2 - 1) k = TB_LOG2 - 1;
    mask = (1 << k) - 1;
    ev[0] = (mul == 1);
    ev[1] = marm && alarm_match;
    ev[2] = (mrs != 0) && ((mcnt & mask) == mask);
    mpend  |= (ev & ~mflags) & men;
    mflags |= ev;
    cn  = (mcnt + 1) % TPS;
    nul = (mcnt == TPS - 1) ? UPD : ((mul != 0) ? mul - 1 : 0);
    marm = (mul == 1);
    mcnt = cn;
    mul  = nul;
    muip = (cn >= TPS - LEAD) || (nul != 0);
  endtask

  task automatic check_status(input bit [2:0] f, input bit q, input string t);
    chk({"R6 periodic ", t}, int'(rd_data[6]), int'(f[2]));
    chk({"R5 alarm ", t},    int'(rd_data[5]), int'(f[1]));
    chk({"R4 update ", t},   int'(rd_data[4]), int'(f[0]));
    chk({"R11 irqf ", t},    int'(rd_data[7]), int'(q));
    chk({"R8 low bits ", t}, int'(rd_data[3:0]), 0);
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic read_status(input string t);
    bit [7:0] d;
    rd(2'd2, d);
    check_status(mflags, |mpend, t);
    mflags = 0; mpend = 0;
    chk("R8 irq dropped", int'(irq), 0);
  endtask

  task automatic check_mode();
    bit [7:0] d;
    rd(2'd0, d);
    chk("R3 uip", int'(d[7]), int'(muip));
    chk("R12 mode bits", int'(d[6:0]), int'({mdv, mrs}));
  endtask

  task automatic write_mode(input bit [2:0] dv, input bit [3:0] rs);
    wr(2'd0, {1'b0, dv, rs});
    mdv = dv; mrs = rs;
    if (dv[2:1] == 2'b11) begin
      mcnt = 0; mul = 0; marm = 0; muip = 0;
    end
  endtask

  task automatic write_en(input bit [2:0] e);
    wr(2'd1, {1'b0, e, 4'h0});
    men = e;
  endtask

  task automatic do_tick(input bit with_read);
    bit [2:0] sf;
    bit sq;
    @(negedge clk);
    tick_32k = 1;
    if (with_read) begin rd_en = 1; addr = 2'd2; end
    @(negedge clk);
    tick_32k = 0; rd_en = 0;
    if (with_read) begin
      sf = mflags; sq = |mpend;
      mflags = 0; mpend = 0;
      model_tick();
      check_status(sf, sq, "R9 same-cycle");
    end else begin
      model_tick();
    end
    chk("R7 R10 irq level", int'(irq), int'(|mpend));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, nchk);
      $finish;
    end
  end

  initial begin
    bit [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(2'd0, d); chk("R1 mode", int'(d), 8'h20);
    rd(2'd1, d); chk("R1 enable", int'(d), 0);
    rd(2'd2, d); chk("R1 status", int'(d), 0);
    // R12 register map
    wr(2'd1, 8'hFF); men = 3'b111;
    rd(2'd1, d); chk("R12 enable mask", int'(d), 8'h70);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R12 status write ignored", int'(d), 0);
    rd(2'd3, d); chk("R12 spare", int'(d), 0);
    write_mode(3'b010, 4'd11);
    check_mode();
    check_mode();

    // sweep over every rate with varied enables, alarm inputs and reads
    for (int rs = 0; rs < 16; rs++) begin
      write_en(3'(rs * 3 + 1));
      write_mode(3'b010, 4'(rs));
      for (int t = 0; t < 2 * TPS; t++) begin
        alarm_match = ((t / TPS + rs) % 3) != 0;
        do_tick(t % 5 == 4);
        if (t % 3 == 2) read_status("sweep");
        if (t % 7 == 0) check_mode();
      end
      read_status("sweep end");
    end

    // R7 enable set after the event does not raise irq
    write_en(3'b000);
    write_mode(3'b010, 4'd1);
    read_status("R7 prep");
    for (int t = 0; t < 8 && mflags[2] == 0; t++) do_tick(0);
    chk("R7 flag without enable", int'(mflags[2]), 1);
    write_en(3'b100);
    @(negedge clk);
    chk("R7 late enable no irq", int'(irq), 0);
    read_status("R7 late enable");

    // R2 frozen divider
    write_mode(3'b000, 4'd2);
    for (int t = 0; t < 40; t++) do_tick(0);
    read_status("R2 frozen");
    check_mode();
    write_mode(3'b001, 4'd2);
    for (int t = 0; t < 10; t++) do_tick(0);
    read_status("R2 frozen 001");
    // R2 clearing mode
    write_mode(3'b110, 4'd2);
    for (int t = 0; t < 5; t++) do_tick(0);
    check_mode();
    write_en(3'b111);
    write_mode(3'b010, 4'd2);
    alarm_match = 1;
    for (int t = 0; t < TPS + 6; t++) begin
      do_tick(t % 4 == 1);
      if (t % 2 == 0) read_status("R2 resume");
      if (t >= TPS - LEAD - 2) check_mode();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, nchk);
    $finish;
  end

endmodule